// File: doc/BRIEF.md
# SMBus Timeout Monitor

This block watches the two wires of an SMBus segment, along with the local "this device is holding SCL low" indication from its own controller, and reports when the bus has stalled. It provides two independent timers, and both count ticks from a programmable prescaler.

The window timer compares a continuous run against threshold A. In low-detect mode the run is SCL held low. In idle-detect mode the run is SCL and SDA both held high. The extend timer adds up the ticks during which this device is stretching the clock, and compares the total against threshold B. It clears at every START or STOP seen on the bus.

When either timer expires, a recovery state machine issues a one-cycle request. A controller acting as master receives a request to issue STOP. A controller acting as slave receives a request to let go of both lines. The same event sets a sticky status flag, which can raise an interrupt.

Top module: `smb_timeout_mon`

## Requirements
- R1: After reset, `timeout_flag`, `irq`, `stop_req` and `release_req` are all 0.
- R2: With `idle_mode`=0 and `win_en`=1, SCL held low for N = max(`thr_a`,1) consecutive ticks causes one timeout.
- R3: In low-detect mode, SCL going high restarts the window count from zero, so runs shorter than N ticks separated by high periods never time out.
- R4: With `idle_mode`=1, SCL and SDA both held high for N ticks causes a timeout, and either line going low restarts the count.
- R5: Ticks on which `stretching`=1 add up across gaps. The tick that brings the total to max(`thr_b`,1) causes one timeout.
- R6: A START (SDA falling while SCL is high) or a STOP (SDA rising while SCL is high) clears the accumulated extend total.
- R7: A timeout while `is_master`=1 produces a single-cycle `stop_req` pulse and no `release_req`.
- R8: A timeout while `is_master`=0 produces a single-cycle `release_req` pulse and no `stop_req`.
- R9: A timer that has fired stays silent until its condition is broken (or, for the extend timer, a START or STOP occurs), so one event gives one pulse.
- R10: `timeout_flag` is set by any timeout and holds until `flag_clr` is pulsed. A timeout in the same cycle as a clear wins.
- R11: `irq` is high exactly when `timeout_flag`=1 and `err_ie`=1.
- R12: With `win_en`=0 the window timer never fires. With `ext_en`=0 the extend timer never fires.
- R13: A tick occurs once every `presc_div`+1 clock cycles. With the two synchroniser stages, a SCL-low timeout request appears between 4+(N-1)(`presc_div`+1) and that value plus `presc_div` clock edges after SCL falls.

States:
- Window timer: WIN_WATCH (counting) and WIN_HELD (fired, waiting for the condition to break).
- Extend timer: EXT_COUNT and EXT_HELD (fired, waiting for START, STOP or disable).
- Recovery: REC_IDLE, REC_STOP and REC_RELEASE. Any timer firing moves the recovery machine to REC_STOP or REC_RELEASE, chosen by `is_master`. With no firing it returns to REC_IDLE on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| presc_div | input | PRESC_W | Tick period minus one, in clocks |
| thr_a | input | THR_W | Window threshold in ticks |
| thr_b | input | THR_W | Cumulative extend threshold in ticks |
| idle_mode | input | 1 | 0: SCL-low detect, 1: bus-idle detect |
| win_en | input | 1 | Window timer enable |
| ext_en | input | 1 | Extend timer enable |
| err_ie | input | 1 | Interrupt enable |
| is_master | input | 1 | 1: acting as master, 0: acting as slave |
| stretching | input | 1 | This device is holding SCL low |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| timeout_flag | output | 1 | Sticky timeout status |
| irq | output | 1 | Interrupt request |
| stop_req | output | 1 | Pulse: generate STOP (master) |
| release_req | output | 1 | Pulse: release SDA and SCL (slave) |

## Verification
The bench builds the block with a 3-bit prescaler, 12-bit thresholds and two synchroniser stages. This keeps every prescaler phase offset small enough to sweep in full. It sweeps thresholds 0 to 6 against divisors 0 to 3 in both window modes, so the zero-threshold corner and every tick alignment are checked against an exact arithmetic latency window. For the extend timer, the bench sweeps every split of the threshold across a stretching gap. It also checks clearing by START and STOP, the disables, and the master and slave recovery paths.

// File: rtl/smb_to_pkg.sv
package smb_to_pkg;
    typedef enum logic [0:0] {WIN_WATCH, WIN_HELD} win_state_t;
    typedef enum logic [0:0] {EXT_COUNT, EXT_HELD} ext_state_t;
    typedef enum logic [1:0] {REC_IDLE, REC_STOP, REC_RELEASE} rec_state_t;
endpackage

// File: rtl/smb_to_tick.sv
// Free-running prescaler: one-cycle tick every div+1 clocks.
module smb_to_tick #(
    parameter int PRESC_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] div,
    output logic               tick
);
    logic [PRESC_W-1:0] pcnt;

    assign tick = (pcnt >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pcnt <= '0;
        else if (tick) pcnt <= '0;
        else           pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/smb_to_sync.sv
// Line synchronisers plus START / STOP detection on the synchronised lines.
module smb_to_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic bus_edge
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic              scl_d, sda_d;

    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [STAGES-1:0] sr;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '1;
            else        sr <= {sr[STAGES-2:0], raw[g]};
        end
        assign synced[g] = sr[STAGES-1];
    end

    assign scl_s = synced[0];
    assign sda_s = synced[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // START: SDA falls with SCL high; STOP: SDA rises with SCL high.
    assign bus_edge = scl_s && scl_d && (sda_d != sda_s);
endmodule

// File: rtl/smb_to_win.sv
// Continuous-run timer against threshold A (SCL-low or bus-idle).
module smb_to_win
    import smb_to_pkg::*;
#(
    parameter int THR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic             idle_mode,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic [THR_W-1:0] thr,
    output logic             fire
);
    localparam int CW = THR_W + 1;

    win_state_t       state_q, state_nx;
    logic [THR_W-1:0] cnt;
    logic [CW-1:0]    cnt_inc;
    logic             cond, reach, hit;

    assign cond    = en && (idle_mode ? (scl_s && sda_s) : !scl_s);
    assign cnt_inc = {1'b0, cnt} + CW'(1);
    assign reach   = (cnt_inc >= {1'b0, thr});
    assign hit     = (state_q == WIN_WATCH) && cond && tick && reach;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            WIN_WATCH: if (hit)   state_nx = WIN_HELD;
            WIN_HELD:  if (!cond) state_nx = WIN_WATCH;
            default:              state_nx = WIN_WATCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WIN_WATCH;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            fire <= 1'b0;
        end else begin
            fire <= hit;
            if (!cond || hit || state_q == WIN_HELD) cnt <= '0;
            else if (tick)                           cnt <= cnt_inc[THR_W-1:0];
        end
    end
endmodule

// File: rtl/smb_to_ext.sv
// Cumulative clock-extend timer against threshold B.
module smb_to_ext
    import smb_to_pkg::*;
#(
    parameter int THR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic             stretching,
    input  logic             bus_edge,
    input  logic [THR_W-1:0] thr,
    output logic             fire
);
    localparam int CW = THR_W + 1;

    ext_state_t       state_q, state_nx;
    logic [THR_W-1:0] acc;
    logic [CW-1:0]    acc_inc;
    logic             restart, step, hit;

    assign restart = bus_edge || !en;
    assign step    = stretching && tick && !restart;
    assign acc_inc = {1'b0, acc} + CW'(1);
    assign hit     = (state_q == EXT_COUNT) && step && (acc_inc >= {1'b0, thr});

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            EXT_COUNT: if (hit)     state_nx = EXT_HELD;
            EXT_HELD:  if (restart) state_nx = EXT_COUNT;
            default:                state_nx = EXT_COUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EXT_COUNT;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc  <= '0;
            fire <= 1'b0;
        end else begin
            fire <= hit;
            if (restart || hit || state_q == EXT_HELD) acc <= '0;
            else if (step)                             acc <= acc_inc[THR_W-1:0];
        end
    end
endmodule

// File: rtl/smb_timeout_mon.sv
module smb_timeout_mon
    import smb_to_pkg::*;
#(
    parameter int PRESC_W     = 4,
    parameter int THR_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic [PRESC_W-1:0] presc_div,
    input  logic [THR_W-1:0]   thr_a,
    input  logic [THR_W-1:0]   thr_b,
    input  logic               idle_mode,
    input  logic               win_en,
    input  logic               ext_en,
    input  logic               err_ie,
    input  logic               is_master,
    input  logic               stretching,
    input  logic               flag_clr,
    output logic               timeout_flag,
    output logic               irq,
    output logic               stop_req,
    output logic               release_req
);
    logic       tick, scl_s, sda_s, bus_edge;
    logic       fire_a, fire_b, any_fire;
    rec_state_t rec_q, rec_nx;

    smb_to_tick #(.PRESC_W(PRESC_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .div(presc_div), .tick(tick)
    );

    smb_to_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .bus_edge(bus_edge)
    );

    smb_to_win #(.THR_W(THR_W)) u_win (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(win_en),
        .idle_mode(idle_mode), .scl_s(scl_s), .sda_s(sda_s),
        .thr(thr_a), .fire(fire_a)
    );

    smb_to_ext #(.THR_W(THR_W)) u_ext (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(ext_en),
        .stretching(stretching), .bus_edge(bus_edge),
        .thr(thr_b), .fire(fire_b)
    );

    assign any_fire = fire_a || fire_b;

    always_comb begin
        rec_nx = REC_IDLE;
        unique case (rec_q)
            REC_IDLE, REC_STOP, REC_RELEASE:
                if (any_fire) rec_nx = is_master ? REC_STOP : REC_RELEASE;
            default: rec_nx = REC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rec_q <= REC_IDLE;
        else        rec_q <= rec_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        timeout_flag <= 1'b0;
        else if (any_fire) timeout_flag <= 1'b1;
        else if (flag_clr) timeout_flag <= 1'b0;
    end

    always_comb begin
        stop_req    = (rec_q == REC_STOP);
        release_req = (rec_q == REC_RELEASE);
        irq         = timeout_flag && err_ie;
    end
endmodule

// File: rtl/smb_timeout_chk.sv
module smb_timeout_chk (
    input logic clk,
    input logic rst_n,
    input logic stop_req,
    input logic release_req,
    input logic timeout_flag,
    input logic flag_clr,
    input logic irq,
    input logic err_ie,
    input logic is_master,
    input logic fire_a,
    input logic fire_b
);
    a_r7_stop_when_master: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |-> $past(is_master));
    a_r8_release_when_slave: assert property (@(posedge clk) disable iff (!rst_n)
        release_req |-> !$past(is_master));
    a_r7_requests_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(stop_req && release_req));
    a_r9_window_single: assert property (@(posedge clk) disable iff (!rst_n)
        fire_a |=> !fire_a);
    a_r9_extend_single: assert property (@(posedge clk) disable iff (!rst_n)
        fire_b |=> !fire_b);
    a_r10_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_flag && !flag_clr) |=> timeout_flag);
    a_r10_flag_with_request: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req || release_req) |-> timeout_flag);
    a_r11_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !err_ie |-> !irq);
    a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> timeout_flag);
endmodule

bind smb_timeout_mon smb_timeout_chk u_chk (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .release_req(release_req),
    .timeout_flag(timeout_flag), .flag_clr(flag_clr), .irq(irq),
    .err_ie(err_ie), .is_master(is_master), .fire_a(fire_a), .fire_b(fire_b)
);

// File: tb/test_smb_timeout_mon.sv
module test_smb_timeout_mon;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 3;
    localparam int TW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl_in = 1'b1, sda_in = 1'b1;
    logic [PW-1:0] presc_div = '0;
    logic [TW-1:0] thr_a = '0, thr_b = '0;
    logic          idle_mode = 1'b0, win_en = 1'b0, ext_en = 1'b0;
    logic          err_ie = 1'b0, is_master = 1'b1, stretching = 1'b0, flag_clr = 1'b0;
    logic          timeout_flag, irq, stop_req, release_req;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_timeout_mon #(.PRESC_W(PW), .THR_W(TW), .SYNC_STAGES(2)) i_smb_timeout_mon (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .presc_div(presc_div), .thr_a(thr_a), .thr_b(thr_b),
        .idle_mode(idle_mode), .win_en(win_en), .ext_en(ext_en),
        .err_ie(err_ie), .is_master(is_master), .stretching(stretching),
        .flag_clr(flag_clr), .timeout_flag(timeout_flag), .irq(irq),
        .stop_req(stop_req), .release_req(release_req)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Count edges until a request pulse is seen (sampled at negedge).
    task automatic wait_req(input int limit, output int n, output logic gs, output logic gr);
        n = 0; gs = 1'b0; gr = 1'b0;
        while (n < limit && !gs && !gr) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            gs = stop_req;
            gr = release_req;
        end
    endtask

    // Watch a window; return number of cycles with any request.
    task automatic quiet(input int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (stop_req || release_req) hits++;
        end
    endtask

    task automatic idle_bus();
        scl_in = 1'b1; sda_in = 1'b1; win_en = 1'b0; ext_en = 1'b0;
        stretching = 1'b0;
        cyc(6);
        flag_clr = 1'b1;
        cyc(1);
        flag_clr = 1'b0;
    endtask

    task automatic run_win(input logic mode, input int thr, input int pd,
                           input logic mst, input logic eie);
        int n, hits, nn, lo, hi;
        logic gs, gr;
        idle_bus();
        idle_mode = mode; thr_a = TW'(thr); presc_div = PW'(pd);
        is_master = mst; err_ie = eie;
        if (mode) begin
            sda_in = 1'b0;
            cyc(5);
            win_en = 1'b1; sda_in = 1'b1;
        end else begin
            win_en = 1'b1; scl_in = 1'b0;
        end
        nn = (thr == 0) ? 1 : thr;
        lo = 4 + (nn - 1) * (pd + 1);
        hi = lo + pd;
        wait_req(hi + 20, n, gs, gr);
        check(gs || gr, mode ? "R4" : "R2", int'(gs || gr), 1);
        check(n >= lo && n <= hi, "R13", n, lo);
        if (mst) check(gs && !gr, "R7", int'({gs, gr}), 2);
        else     check(gr && !gs, "R8", int'({gs, gr}), 1);
        quiet(2 * hi + 4, hits);
        check(hits == 0, "R9", hits, 0);
        check(timeout_flag == 1'b1, "R10", int'(timeout_flag), 1);
        check(irq == eie, "R11", int'(irq), int'(eie));
        win_en = 1'b0; scl_in = 1'b1; sda_in = 1'b1;
        cyc(4);
        check(timeout_flag == 1'b1, "R10", int'(timeout_flag), 1);
        flag_clr = 1'b1;
        cyc(1);
        flag_clr = 1'b0;
        check(timeout_flag == 1'b0 && irq == 1'b0, "R10", int'(timeout_flag), 0);
    endtask

    // Extend timer: k stretching ticks, a gap, then continue until fire.
    task automatic run_ext(input int thr, input int k);
        int n, hits;
        logic gs, gr;
        idle_bus();
        presc_div = '0; thr_b = TW'(thr); is_master = 1'b1; ext_en = 1'b1;
        if (k > 0) begin
            stretching = 1'b1;
            cyc(k);
            stretching = 1'b0;
            quiet(3, hits);
            check(hits == 0, "R5", hits, 0);
        end
        stretching = 1'b1;
        wait_req(thr + 10, n, gs, gr);
        stretching = 1'b0;
        check(gs, "R5", int'(gs), 1);
        check(n == ((thr == 0 ? 1 : thr) - k + 1), "R5", n, (thr == 0 ? 1 : thr) - k + 1);
    endtask

    initial begin
        int n, hits;
        logic gs, gr;
        cyc(3);
        check(timeout_flag == 0 && irq == 0 && stop_req == 0 && release_req == 0,
              "R1", int'({timeout_flag, irq, stop_req, release_req}), 0);
        rst_n = 1'b1;
        cyc(2);
        check(timeout_flag == 0 && stop_req == 0 && release_req == 0, "R1",
              int'({timeout_flag, stop_req, release_req}), 0);

        // Window sweeps: both modes, thresholds 0..6, divisors 0..3.
        for (int m = 0; m < 2; m++)
            for (int t = 0; t <= 6; t++)
                for (int p = 0; p <= 3; p++)
                    run_win(m[0], t, p, t[0] ^ m[0], p[0]);

        // R3: SCL-low runs of N-1 ticks separated by highs never fire.
        idle_bus();
        idle_mode = 1'b0; thr_a = 12'd5; presc_div = '0; win_en = 1'b1; is_master = 1'b1;
        for (int r = 0; r < 3; r++) begin
            scl_in = 1'b0; cyc(4);
            scl_in = 1'b1; cyc(3);
        end
        quiet(10, hits);
        check(hits == 0, "R3", hits, 0);

        // R4: idle runs broken by either line going low never fire.
        idle_bus();
        idle_mode = 1'b1; thr_a = 12'd5; sda_in = 1'b0; cyc(5);
        win_en = 1'b1;
        sda_in = 1'b1; cyc(4);
        sda_in = 1'b0; cyc(2);
        sda_in = 1'b1; cyc(4);
        scl_in = 1'b0; cyc(2);
        scl_in = 1'b1; cyc(4);
        sda_in = 1'b0;
        quiet(10, hits);
        check(hits == 0, "R4", hits, 0);

        // R12: disabled window timer ignores a long SCL low.
        idle_bus();
        idle_mode = 1'b0; thr_a = 12'd2; win_en = 1'b0; scl_in = 1'b0;
        quiet(20, hits);
        check(hits == 0 && timeout_flag == 0, "R12", hits, 0);
        scl_in = 1'b1;

        // R5: every split of the threshold around a gap.
        for (int t = 1; t <= 5; t++)
            for (int k = 0; k < t; k++)
                run_ext(t, k);
        run_ext(0, 0);

        // R9: extend timer holds after firing while stretching continues.
        idle_bus();
        thr_b = 12'd3; ext_en = 1'b1; stretching = 1'b1;
        wait_req(20, n, gs, gr);
        check(gs, "R9", int'(gs), 1);
        quiet(15, hits);
        check(hits == 0, "R9", hits, 0);
        stretching = 1'b0;

        // R6: START clears the accumulated total.
        idle_bus();
        thr_b = 12'd4; ext_en = 1'b1;
        stretching = 1'b1; cyc(3); stretching = 1'b0;
        sda_in = 1'b0; cyc(6);
        stretching = 1'b1;
        wait_req(20, n, gs, gr);
        stretching = 1'b0;
        check(gs && n == 5, "R6", n, 5);
        // R6: STOP clears the accumulated total.
        stretching = 1'b1; cyc(3); stretching = 1'b0;
        sda_in = 1'b1; cyc(6);
        stretching = 1'b1;
        wait_req(20, n, gs, gr);
        stretching = 1'b0;
        check(gs && n == 5, "R6", n, 5);

        // R12: disabled extend timer ignores stretching.
        idle_bus();
        thr_b = 12'd2; ext_en = 1'b0; stretching = 1'b1;
        quiet(20, hits);
        check(hits == 0 && timeout_flag == 0, "R12", hits, 0);
        stretching = 1'b0;

        // R8 / R11: slave recovery with interrupt enabled.
        idle_bus();
        thr_b = 12'd2; ext_en = 1'b1; is_master = 1'b0; err_ie = 1'b1; stretching = 1'b1;
        wait_req(20, n, gs, gr);
        stretching = 1'b0;
        check(gr && !gs && n == 3, "R8", n, 3);
        cyc(1);
        check(irq == 1'b1, "R11", int'(irq), 1);
        err_ie = 1'b0;
        #1;
        check(irq == 1'b0 && timeout_flag == 1'b1, "R11", int'(irq), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule